// File: doc/BRIEF.md
# Masked Counter Sum Quota Monitor

This block watches a bank of event counters and raises a quota interrupt once the total of a chosen subset of them goes above a programmed limit. A mask selects which counters take part. The block does not add all counters at once. An index steps through the counters, one per enabled cycle. Each selected counter value is added into a wide accumulator, and the running total is compared against the limit at every step.

After the last counter in a pass, the accumulator is cleared and a fresh pass begins at index 0. The interrupt is sticky. Only a soft reset or a hard reset clears it. The mask is latched internally while the soft reset input is high. Between soft reset pulses, changes on the mask input have no effect. Software therefore writes the mask and then pulses the soft reset to apply it.

Top module: `quota_sum_monitor`

## Requirements
- R1: After hard reset (rst_n low), quota_irq is 0, total is 0, the index is 0 and the latched mask is all zeros.
- R2: In each cycle with enable high and soft_rst low, exactly one counter is visited, in index order 0, 1, ..., N_CNT-1. The counter with index i occupies bits [i*CNT_W +: CNT_W] of counters. total then shows the sum of the selected counters visited so far in the pass. After index N_CNT-1 has been visited, total returns to 0 and the next pass starts at index 0.
- R3: The accumulator is CNT_W + log2(N_CNT) bits wide. It holds the sum of all counters at their maximum value without wrapping, and total never wraps within a pass.
- R4: A counter adds to the total only when its bit in the latched mask is 1. Bit i of the mask belongs to counter i.
- R5: quota_irq becomes 1 at the clock edge that visits a counter and brings the running total strictly above limit. A total equal to limit does not raise it.
- R6: With every counter at 1, every mask bit set and limit = N_CNT-1, quota_irq is 1 after N_CNT enabled cycles and 0 before that.
- R7: With every counter at its maximum value and a latched mask of all zeros, quota_irq never asserts.
- R8: Once set, quota_irq stays 1 until a soft or hard reset, even if later passes give a smaller total.
- R9: While soft_rst is high, quota_irq, total and the index are cleared and the mask is latched from mask_cfg. At any other time, changes on mask_cfg are ignored.
- R10: While enable is low and soft_rst is low, the index, total and quota_irq hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| enable | input | 1 | Advances the scan when high |
| soft_rst | input | 1 | Synchronous clear; latches mask_cfg |
| counters | input | N_CNT*CNT_W | Flattened counter values, counter i at [i*CNT_W +: CNT_W] |
| mask_cfg | input | N_CNT | Counter select mask, bit i for counter i |
| limit | input | CNT_W | Quota threshold |
| quota_irq | output | 1 | Sticky quota interrupt |
| total | output | CNT_W+log2(N_CNT) | Running masked total of the current pass |

## Verification
Both outputs are registered, so every effect of an input appears one clock edge after that input is sampled. A visited counter changes total at the next edge. A running sum above limit raises quota_irq at that same edge. A soft reset clears both outputs one edge after it is sampled high. A full pass takes N_CNT enabled edges before total returns to 0. Inputs change on the falling edge, and the behavioural model advances on the rising edge. The outputs are compared with the model on every falling edge. Further hand-computed checks sample after an exact count of falling edges from the soft reset release, for example N_CNT-1 and N_CNT edges for the threshold case.

// File: rtl/quota_sum_monitor.sv
module quota_sum_monitor #(
  parameter int N_CNT = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1,
  localparam int ACC_W = CNT_W + IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   soft_rst,
  input  logic [N_CNT*CNT_W-1:0] counters,
  input  logic [N_CNT-1:0]       mask_cfg,
  input  logic [CNT_W-1:0]       limit,
  output logic                   quota_irq,
  output logic [ACC_W-1:0]       total
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CNT - 1);

  logic [N_CNT-1:0] mask_q;
  logic [IDX_W-1:0] idx;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cur;
  logic [ACC_W-1:0] sum;
  logic             over;

  assign cur   = counters[int'(idx)*CNT_W +: CNT_W];
  assign sum   = acc + (mask_q[idx] ? ACC_W'(cur) : '0);
  assign over  = sum > ACC_W'(limit);
  assign total = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      idx       <= '0;
      acc       <= '0;
      quota_irq <= 1'b0;
    end else if (soft_rst) begin
      mask_q    <= mask_cfg;
      idx       <= '0;
      acc       <= '0;
      quota_irq <= 1'b0;
    end else if (enable) begin
      quota_irq <= quota_irq | over;
      if (idx == LAST) begin
        idx <= '0;
        acc <= '0;
      end else begin
        idx <= idx + 1'b1;
        acc <= sum;
      end
    end
  end

endmodule

module quota_sum_monitor_chk #(
  parameter int N_CNT = 16,
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             soft_rst,
  input logic             quota_irq,
  input logic [ACC_W-1:0] total,
  input logic [N_CNT-1:0] mask_q
);

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (live && quota_irq && !soft_rst) |=> quota_irq);

  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!quota_irq && total == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !enable && !soft_rst) |=> ($stable(total) && $stable(quota_irq)));

  a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mask_q == '0) |-> total == '0);

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (live && enable && !soft_rst) |=> (total >= $past(total) || total == '0));

endmodule

bind quota_sum_monitor quota_sum_monitor_chk #(.N_CNT(N_CNT), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
  .quota_irq(quota_irq), .total(total), .mask_q(mask_q)
);

// File: tb/sim_quota_sum_monitor.sv
module sim_quota_sum_monitor;
  localparam int N = 16;
  localparam int W = 32;
  localparam int AW = W + $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic soft_rst = 1'b0;
  logic [N*W-1:0] cnt_flat = '0;
  logic [N-1:0] mask_cfg = '0;
  logic [W-1:0] limit = '0;
  logic quota_irq;
  logic [AW-1:0] total;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  quota_sum_monitor #(.N_CNT(N), .CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .counters(cnt_flat), .mask_cfg(mask_cfg), .limit(limit),
    .quota_irq(quota_irq), .total(total)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  longint m_acc;
  int m_idx;
  bit m_irq;
  bit [N-1:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_idx = 0; m_irq = 0; m_mask = '0;
    end else if (soft_rst) begin
      m_acc = 0; m_idx = 0; m_irq = 0; m_mask = mask_cfg;
    end else if (enable) begin
      longint s;
      s = m_acc;
      if (m_mask[m_idx]) s = s + longint'(cnt_flat[m_idx*W +: W]);
      if (s > longint'(limit)) m_irq = 1;
      if (m_idx == N - 1) begin m_idx = 0; m_acc = 0; end
      else begin m_idx = m_idx + 1; m_acc = s; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      vectors++;
      if (quota_irq !== m_irq || total !== AW'(m_acc)) begin
        errors++;
        $display("FAIL %s: irq=%0b total=%0d expected irq=%0b total=%0d",
                 phase, quota_irq, total, m_irq, m_acc);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_all(input logic [W-1:0] v);
    for (int i = 0; i < N; i++) cnt_flat[i*W +: W] = v;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_pulse(input logic [N-1:0] m);
    mask_cfg = m;
    soft_rst = 1'b1;
    tick(1);
    soft_rst = 1'b0;
  endtask

  initial begin
    tick(3);
    chk("R1 irq", quota_irq, 0);
    chk("R1 total", total, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    set_all(32'd5);
    limit = 32'd1;
    tick(N);
    chk("R1 mask zero after reset", total, 0);
    chk("R1 irq stays low", quota_irq, 0);

    phase = "R6";
    enable = 1'b0;
    set_all(32'd1);
    limit = N - 1;
    soft_pulse('1);
    enable = 1'b1;
    tick(N - 1);
    chk("R6 total before last", total, N - 1);
    chk("R6 irq before last", quota_irq, 0);
    tick(1);
    chk("R6 irq after N", quota_irq, 1);
    chk("R2 total wraps to 0", total, 0);

    phase = "R8";
    limit = '1;
    tick(2 * N);
    chk("R8 sticky irq", quota_irq, 1);

    phase = "R5";
    limit = N;
    soft_pulse('1);
    chk("R9 soft clears irq", quota_irq, 0);
    tick(3 * N);
    chk("R5 equal does not trigger", quota_irq, 0);

    phase = "R4";
    for (int i = 0; i < N; i++) cnt_flat[i*W +: W] = W'(i + 1);
    limit = '1;
    soft_pulse(16'hA5C3);
    tick(N - 1);
    begin
      longint e = 0;
      for (int i = 0; i < N - 1; i++) if (16'hA5C3 >> i & 1) e += i + 1;
      chk("R4 masked sum", total, e);
    end
    tick(1);

    phase = "R2";
    tick(4);
    chk("R2 partial pass", total, 1 + 2);

    phase = "R9";
    mask_cfg = '0;
    tick(N);
    chk("R9 mask change ignored", total, 1 + 2);

    phase = "R10";
    enable = 1'b0;
    tick(5);
    chk("R10 hold total", total, 1 + 2);
    set_all(32'd9);
    limit = '0;
    tick(3);
    chk("R10 no irq while disabled", quota_irq, 0);
    enable = 1'b1;

    phase = "R3";
    limit = '1;
    set_all('1);
    soft_pulse('1);
    tick(N - 1);
    chk("R3 wide total", total, longint'(N - 1) * 64'hFFFF_FFFF);
    chk("R3 irq above max limit", quota_irq, 1);
    tick(1);

    phase = "R7";
    soft_pulse('0);
    tick(3 * N);
    chk("R7 never fires", quota_irq, 0);
    chk("R7 total zero", total, 0);

    phase = "R1";
    rst_n = 1'b0;
    tick(1);
    chk("R1 hard reset irq", quota_irq, 0);
    rst_n = 1'b1;
    tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule